// File: doc/BRIEF.md
# Zero-Cross Synchronized Gain Updater

This block decides when a new 8-bit gain code reaches each channel of a stereo attenuator and gain stage. A serial front end latches a left and a right code and pulses a strobe. With zero-cross gating turned on, each channel keeps the new code pending. It moves the code to its active register only after two zero-crossing pulses from that channel's own comparator, so that level steps fall on points of low signal energy. A cycle-count timeout applies the code anyway if the signal never crosses zero, for example on DC or on silence.

When the gating enable is low, both the crossing wait and the timeout are skipped and a latched code takes effect on the next clock edge. The active code is also decoded to a signed gain in half-dB steps. Code 0x00 raises a separate mute flag, because at that code the stage runs at unity gain with its input tied to the point of maximum attenuation.

Top module: `zc_gain_updater`

## Requirements
- R1: After reset both active codes are 0x00, both mute flags are high and both pending flags are low.
- R2: When `latchStb` is sampled high with `zcEnable` low, both active codes take the input codes on that same clock edge and both pending flags are low afterwards.
- R3: When `latchStb` is sampled high with `zcEnable` high, both pending flags go high on that edge and both active codes keep their previous values.
- R4: A pending code becomes active on the clock edge that samples the second zero-crossing pulse of its channel since the latch. The pending flag falls on that same edge.
- R5: Left and right are tracked separately. Crossing pulses on one channel never apply the other channel's pending code.
- R6: If two crossings have not been seen, a pending code is applied on the edge that comes TIMEOUT clock cycles after the latching edge. TIMEOUT = CLK_FREQ_HZ/1000 × TIMEOUT_MS, with a default of 18 ms.
- R7: A latch that arrives while a code is pending replaces the pending code and restarts both the crossing count and the timeout. The older code never becomes active.
- R8: If `zcEnable` is low while a code is pending, the pending code is applied on the next clock edge.
- R9: The gain output is a 9-bit two's-complement value equal to the active code minus 192. For example, 0xFF gives +63, 0xC0 gives 0, 0x80 gives −64, 0x01 gives −191 and 0x00 gives −192.
- R10: A channel's mute flag is high exactly when its active code is 0x00.
- R11: Zero-crossing pulses that arrive while no code is pending change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchStb | input | 1 | One-cycle strobe that presents new codes |
| leftCodeIn | input | 8 | Newly latched left code |
| rightCodeIn | input | 8 | Newly latched right code |
| zcLeft | input | 1 | Left zero-crossing pulse, one cycle per crossing |
| zcRight | input | 1 | Right zero-crossing pulse, one cycle per crossing |
| zcEnable | input | 1 | High: wait for crossings or timeout; low: apply at once |
| leftCode | output | 8 | Active left code |
| rightCode | output | 8 | Active right code |
| leftMute | output | 1 | Left software-mute flag |
| rightMute | output | 1 | Right software-mute flag |
| leftGain | output | 9 | Left gain in signed half-dB steps |
| rightGain | output | 9 | Right gain in signed half-dB steps |
| leftPending | output | 1 | Left update waiting |
| rightPending | output | 1 | Right update waiting |

## Verification
The checker verifies the following properties on every cycle:
- a bypass latch lands on the next edge;
- a gated latch raises pending and leaves the active codes untouched;
- active codes stay frozen while pending holds;
- no pending window outlasts the timeout, measured by a counter;
- mute always implies a code of zero and the lowest gain.

Some behaviours need scripted sequences, which only the bench scenarios provide:
- the exact edge of the second crossing;
- channel independence;
- replacement of a pending code by a newer one;
- the exact timeout edge;
- the fact that a superseded code never appears on the outputs.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

  // strobes from control to datapath, one set per channel
  typedef struct packed {
    logic applyNew;   // take input code directly into active register
    logic loadPend;   // capture input code into pending register
    logic applyPend;  // move pending register into active register
  } zcg_strobe_t;

endpackage

// File: rtl/zcg_ctrl.sv
module zcg_ctrl
  import zcg_pkg::*;
#(
  parameter int NUM_CH         = 2,
  parameter int ZC_NEEDED      = 2,
  parameter int TIMEOUT_CYCLES = 1800000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      latchStb,
  input  logic                      zcEnable,
  input  logic [NUM_CH-1:0]         zcPulse,
  output zcg_strobe_t [NUM_CH-1:0]  strobes,
  output logic [NUM_CH-1:0]         pending
);

  localparam int ZC_W  = (ZC_NEEDED > 1) ? $clog2(ZC_NEEDED) : 1;
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [ZC_W-1:0]  ZC_LAST  = ZC_W'(ZC_NEEDED - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic             pendQ;
    logic [ZC_W-1:0]  zcCnt;
    logic [TMR_W-1:0] tmr;
    logic             zcDone;
    logic             tmrDone;
    logic             applyNow;
    zcg_strobe_t      st;

    assign zcDone   = zcPulse[ch] && (zcCnt == ZC_LAST);
    assign tmrDone  = (tmr == TMR_LAST);
    // a fresh latch always wins over completion of the older update
    assign applyNow = pendQ && !latchStb && (!zcEnable || zcDone || tmrDone);

    always_comb begin
      st.applyNew  = latchStb && !zcEnable;
      st.loadPend  = latchStb && zcEnable;
      st.applyPend = applyNow;
    end

    assign strobes[ch] = st;
    assign pending[ch] = pendQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        zcCnt <= '0;
        tmr   <= '0;
      end else if (latchStb) begin
        pendQ <= zcEnable;
        zcCnt <= '0;
        tmr   <= '0;
      end else if (applyNow) begin
        pendQ <= 1'b0;
        zcCnt <= '0;
        tmr   <= '0;
      end else if (pendQ) begin
        tmr <= tmr + 1'b1;
        if (zcPulse[ch]) zcCnt <= zcCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/zcg_datapath.sv
module zcg_datapath
  import zcg_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CODE_W     = 8,
  parameter int UNITY_CODE = 192
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_CH-1:0][CODE_W-1:0]       newCode,
  input  zcg_strobe_t [NUM_CH-1:0]            strobes,
  output logic [NUM_CH-1:0][CODE_W-1:0]       actCode,
  output logic [NUM_CH-1:0][CODE_W:0]         gain,
  output logic [NUM_CH-1:0]                   mute
);

  localparam int GAIN_W = CODE_W + 1;
  localparam logic signed [GAIN_W-1:0] UNITY = GAIN_W'(UNITY_CODE);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [CODE_W-1:0] pendCode;
    logic [CODE_W-1:0] actQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendCode <= '0;
        actQ     <= '0;
      end else begin
        if (strobes[ch].loadPend)  pendCode <= newCode[ch];
        if (strobes[ch].applyNew)  actQ     <= newCode[ch];
        else if (strobes[ch].applyPend) actQ <= pendCode;
      end
    end

    assign actCode[ch] = actQ;
    assign gain[ch]    = $signed({1'b0, actQ}) - UNITY;
    assign mute[ch]    = (actQ == '0);
  end

endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater
  import zcg_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CLK_FREQ_HZ = 100000000,
  parameter int TIMEOUT_MS  = 18,
  parameter int ZC_NEEDED   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchStb,
  input  logic [CODE_W-1:0] leftCodeIn,
  input  logic [CODE_W-1:0] rightCodeIn,
  input  logic              zcLeft,
  input  logic              zcRight,
  input  logic              zcEnable,
  output logic [CODE_W-1:0] leftCode,
  output logic [CODE_W-1:0] rightCode,
  output logic              leftMute,
  output logic              rightMute,
  output logic [CODE_W:0]   leftGain,
  output logic [CODE_W:0]   rightGain,
  output logic              leftPending,
  output logic              rightPending
);

  localparam int NUM_CH         = 2;
  localparam int TIMEOUT_CYCLES = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;

  zcg_strobe_t [NUM_CH-1:0]        strobes;
  logic [NUM_CH-1:0]               pending;
  logic [NUM_CH-1:0][CODE_W-1:0]   actCode;
  logic [NUM_CH-1:0][CODE_W:0]     gain;
  logic [NUM_CH-1:0]               mute;

  // channel 0 is left, channel 1 is right
  zcg_ctrl #(
    .NUM_CH(NUM_CH), .ZC_NEEDED(ZC_NEEDED), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .zcEnable(zcEnable),
    .zcPulse({zcRight, zcLeft}), .strobes(strobes), .pending(pending)
  );

  zcg_datapath #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .UNITY_CODE(192)
  ) uData (
    .clk(clk), .rstN(rstN), .newCode({rightCodeIn, leftCodeIn}),
    .strobes(strobes), .actCode(actCode), .gain(gain), .mute(mute)
  );

  assign leftCode     = actCode[0];
  assign rightCode    = actCode[1];
  assign leftGain     = gain[0];
  assign rightGain    = gain[1];
  assign leftMute     = mute[0];
  assign rightMute    = mute[1];
  assign leftPending  = pending[0];
  assign rightPending = pending[1];

endmodule

// File: rtl/zcg_checker.sv
module zcg_checker #(
  parameter int CODE_W      = 8,
  parameter int CLK_FREQ_HZ = 100000000,
  parameter int TIMEOUT_MS  = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              latchStb,
  input logic              zcEnable,
  input logic [CODE_W-1:0] leftCodeIn,
  input logic [CODE_W-1:0] rightCodeIn,
  input logic [CODE_W-1:0] leftCode,
  input logic [CODE_W-1:0] rightCode,
  input logic              leftMute,
  input logic              rightMute,
  input logic [CODE_W:0]   leftGain,
  input logic [CODE_W:0]   rightGain,
  input logic              leftPending,
  input logic              rightPending
);

  localparam int TO    = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;
  localparam int CNT_W = $clog2(TO + 2);
  localparam logic [CODE_W:0] LOW_GAIN = (CODE_W+1)'(-192);

  logic [CNT_W-1:0] leftWait, rightWait;

  always_ff @(posedge clk) begin
    if (!rstN || latchStb || !leftPending) leftWait <= '0;
    else leftWait <= leftWait + 1'b1;
    if (!rstN || latchStb || !rightPending) rightWait <= '0;
    else rightWait <= rightWait + 1'b1;
  end

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && !zcEnable) |=> (leftCode == $past(leftCodeIn)) &&
      (rightCode == $past(rightCodeIn)) && !leftPending && !rightPending);

  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && zcEnable) |=> leftPending && rightPending &&
      $stable(leftCode) && $stable(rightCode));

  assert_left_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (leftPending && $past(leftPending)) |-> $stable(leftCode));

  assert_right_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rightPending && $past(rightPending)) |-> $stable(rightCode));

  assert_left_timeout_R6: assert property (@(posedge clk) disable iff (!rstN)
    leftPending |-> (leftWait < CNT_W'(TO)));

  assert_right_timeout_R6: assert property (@(posedge clk) disable iff (!rstN)
    rightPending |-> (rightWait < CNT_W'(TO)));

  assert_left_mute_R10: assert property (@(posedge clk) disable iff (!rstN)
    leftMute |-> (leftCode == '0) && (leftGain == LOW_GAIN));

  assert_right_mute_R10: assert property (@(posedge clk) disable iff (!rstN)
    rightMute |-> (rightCode == '0) && (rightGain == LOW_GAIN));

endmodule

bind zc_gain_updater zcg_checker #(
  .CODE_W(CODE_W), .CLK_FREQ_HZ(CLK_FREQ_HZ), .TIMEOUT_MS(TIMEOUT_MS)
) uChecker (
  .clk(clk), .rstN(rstN), .latchStb(latchStb), .zcEnable(zcEnable),
  .leftCodeIn(leftCodeIn), .rightCodeIn(rightCodeIn),
  .leftCode(leftCode), .rightCode(rightCode),
  .leftMute(leftMute), .rightMute(rightMute),
  .leftGain(leftGain), .rightGain(rightGain),
  .leftPending(leftPending), .rightPending(rightPending)
);

// File: tb/tb_zc_gain_updater.sv
module tb_zc_gain_updater;

  localparam int CLK_HZ = 100000;   // scaled so the timeout is 1800 cycles
  localparam int TO     = (CLK_HZ / 1000) * 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchStb = 1'b0;
  logic [7:0] leftCodeIn = '0, rightCodeIn = '0;
  logic zcLeft = 1'b0, zcRight = 1'b0, zcEnable = 1'b0;
  logic [7:0] leftCode, rightCode;
  logic leftMute, rightMute, leftPending, rightPending;
  logic [8:0] leftGain, rightGain;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ[2][$];
  logic [7:0] prevCode[2];

  always #5 clk = ~clk;

  zc_gain_updater #(.CLK_FREQ_HZ(CLK_HZ)) dut (
    .clk(clk), .rstN(rstN), .latchStb(latchStb),
    .leftCodeIn(leftCodeIn), .rightCodeIn(rightCodeIn),
    .zcLeft(zcLeft), .zcRight(zcRight), .zcEnable(zcEnable),
    .leftCode(leftCode), .rightCode(rightCode),
    .leftMute(leftMute), .rightMute(rightMute),
    .leftGain(leftGain), .rightGain(rightGain),
    .leftPending(leftPending), .rightPending(rightPending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every change of an active code must match the next expected item
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [7:0] c;
        logic [8:0] g;
        logic m;
        c = (ch == 0) ? leftCode : rightCode;
        g = (ch == 0) ? leftGain : rightGain;
        m = (ch == 0) ? leftMute : rightMute;
        if (c !== prevCode[ch]) begin
          if (expQ[ch].size() == 0) begin
            check(1'b0, "R11 unexpected code change", int'(c), int'(prevCode[ch]));
          end else begin
            logic [7:0] e;
            e = expQ[ch].pop_front();
            check(c == e, "R4 applied code", int'(c), int'(e));
            check($signed(g) == int'(e) - 192, "R9 gain decode",
                  int'($signed(g)), int'(e) - 192);
            check(m == (e == 8'h00), "R10 mute flag", int'(m), int'(e == 8'h00));
          end
          prevCode[ch] = c;
        end
      end
    end
  end

  task automatic latchCodes(input logic [7:0] l, input logic [7:0] r,
                            input bit pushL, input bit pushR);
    @(negedge clk);
    leftCodeIn = l; rightCodeIn = r; latchStb = 1'b1;
    if (pushL) expQ[0].push_back(l);
    if (pushR) expQ[1].push_back(r);
    @(negedge clk);
    latchStb = 1'b0;
  endtask

  task automatic zcPulse(input bit left, input bit right);
    @(negedge clk);
    zcLeft = left; zcRight = right;
    @(negedge clk);
    zcLeft = 1'b0; zcRight = 1'b0;
  endtask

  initial begin
    #(2_000_000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    prevCode[0] = 8'h00; prevCode[1] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(leftCode == 0 && rightCode == 0, "R1 codes zero", int'(leftCode), 0);
    check(leftMute && rightMute, "R1 mute high", int'(leftMute & rightMute), 1);
    check(!leftPending && !rightPending, "R1 pending low", int'(leftPending | rightPending), 0);

    // R2 bypass: immediate apply
    zcEnable = 1'b0;
    latchCodes(8'hC0, 8'hFF, 1, 1);
    check(leftCode == 8'hC0 && rightCode == 8'hFF, "R2 immediate apply", int'(leftCode), 'hC0);
    check(!leftPending && !rightPending, "R2 no pending", int'(leftPending | rightPending), 0);
    check($signed(rightGain) == 63, "R9 top code gain", int'($signed(rightGain)), 63);

    // R3/R4/R5 gated, independent channels
    zcEnable = 1'b1;
    latchCodes(8'h80, 8'h01, 1, 1);
    check(leftPending && rightPending, "R3 pending set", int'(leftPending & rightPending), 1);
    check(leftCode == 8'hC0, "R3 active held", int'(leftCode), 'hC0);
    zcPulse(1, 0);
    check(leftPending && leftCode == 8'hC0, "R4 one crossing not enough", int'(leftCode), 'hC0);
    zcPulse(1, 0);
    check(!leftPending && leftCode == 8'h80, "R4 second crossing applies", int'(leftCode), 'h80);
    check(rightPending && rightCode == 8'hFF, "R5 right unaffected", int'(rightCode), 'hFF);
    zcPulse(0, 1);
    zcPulse(0, 1);
    check(!rightPending && rightCode == 8'h01, "R5 right applies", int'(rightCode), 'h01);

    // R11 stray crossings with nothing pending
    zcPulse(1, 1);
    zcPulse(1, 1);
    check(leftCode == 8'h80 && rightCode == 8'h01 && !leftPending,
          "R11 stray crossings ignored", int'(leftCode), 'h80);

    // R6 timeout
    latchCodes(8'h10, 8'h20, 1, 1);
    repeat (TO - 1) @(negedge clk);
    check(leftPending && leftCode == 8'h80, "R6 still pending before timeout", int'(leftCode), 'h80);
    @(negedge clk);
    check(!leftPending && !rightPending && leftCode == 8'h10 && rightCode == 8'h20,
          "R6 applied at timeout", int'(leftCode), 'h10);

    // R7 replacement restarts counting; R8 enable drop applies pending
    latchCodes(8'h40, 8'h33, 0, 0);
    zcPulse(1, 0);
    latchCodes(8'h50, 8'h44, 1, 1);
    zcPulse(1, 0);
    check(leftPending && leftCode == 8'h10, "R7 crossing count restarted", int'(leftCode), 'h10);
    zcPulse(1, 0);
    check(!leftPending && leftCode == 8'h50, "R7 newest code applied", int'(leftCode), 'h50);
    check(rightPending, "R7 right still pending", int'(rightPending), 1);
    @(negedge clk);
    zcEnable = 1'b0;
    @(negedge clk);
    check(!rightPending && rightCode == 8'h44, "R8 enable drop applies", int'(rightCode), 'h44);

    // R10 software mute code
    latchCodes(8'h00, 8'h02, 1, 1);
    check(leftMute && !rightMute, "R10 mute only at zero", int'(leftMute), 1);

    repeat (3) @(negedge clk);
    check(expQ[0].size() == 0 && expQ[1].size() == 0, "R4 all expected updates seen",
          expQ[0].size() + expQ[1].size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule